// File: doc/BRIEF.md
# Three-Operand Carry-Save Increment Adder

This block adds three unsigned N-bit operands in pure combinational logic and returns their exact sum on an (N+2)-bit result. The first stage is a row of full adders, one per bit position, all working side by side. It reduces the three operands to a partial-sum vector and a carry vector. The carry vector is then moved up by one bit position and merged with the partial-sum vector.

The merge is split into 4-bit slices. Every slice adds its bits with a carry-in of zero, and all slices do so at the same time. The lowest slice goes straight to the result. Each higher slice is then corrected by a chain of half adders. That chain is driven by the carry leaving the slice below it, so the carry between slices never has to pass through full adders. The merge position at bit 0 has a constant-zero carry-vector input, so it uses no adder cell at all. The width N must be a multiple of 4.

Top module: `csi_adder3`

## Requirements
- R1: For every combination of operands, `total` equals the exact unsigned sum `op_a + op_b + op_c`, computed without truncation on N+2 bits.
- R2: When all three operands are all ones, `total` equals 3·(2^N − 1), and `total` never exceeds that value.
- R3: Bits [3:0] of `total` equal the low 4 bits of `op_a[3:0] + op_b[3:0] + op_c[3:0]`, whatever the upper operand bits are.
- R4: When the lowest 4-bit slice produces a carry, the slice above it is incremented by one (for example, 0x0F + 0x01 + 0x00 = 0x010).
- R5: Within any slice, the slice's own partial carry-out and its increment-chain carry-out are never 1 together.
- R6: A slice that receives no carry from the slice below keeps its partial sum unchanged, and its increment chain produces no carry.
- R7: All-zero operands give a `total` of zero.
- R8: A carry from a low slice passes through several all-ones upper slices in turn (for example, at N=16, 0xFFFF + 0x0001 + 0 = 0x10000).
- R9: The result width follows N: at N=16, the maximum operands give 0x2FFFD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| op_c | input | N | Third unsigned operand |
| total | output | N+2 | Unsigned sum of the three operands |

## Verification
Four properties are checked whenever the operands are known: the exact sum, the upper bound, the low-slice independence, and the rule that a slice's partial carry and its increment carry never coincide. A fifth property checks that a slice with no incoming carry produces no increment carry. Some effects can only be shown by chosen operand patterns from the bench. These are a carry leaving the low slice, a carry crossing several all-ones slices in a 16-bit instance, the all-ones maximum, and an unchanged low nibble when only the upper operand bits change.

// File: rtl/csi_adder3.sv
module csi_adder3 #(
  parameter int N = 8
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [N-1:0] op_c,
  output logic [N+1:0] total
);
  localparam int SW = 4;
  localparam int NB = N / SW;

  logic [N-1:0]  row_s;
  logic [N-1:0]  row_c;
  logic [N:0]    row_cs;
  logic [N-1:0]  low_res;
  logic [NB-1:0] part_co;
  logic [NB-1:0] inc_co;
  logic [NB-1:0] blk_co;

  assign row_s  = op_a ^ op_b ^ op_c;
  assign row_c  = (op_a & op_b) | (op_a & op_c) | (op_b & op_c);
  assign row_cs = {row_c, 1'b0};

  always_comb begin
    logic       cy;
    logic       t;
    logic       up;
    logic [SW-1:0] ps;
    up      = 1'b0;
    low_res = '0;
    part_co = '0;
    inc_co  = '0;
    blk_co  = '0;
    for (int k = 0; k < NB; k++) begin
      cy = 1'b0;
      ps = '0;
      for (int i = 0; i < SW; i++) begin
        if (k == 0 && i == 0) begin
          ps[i] = row_s[0];
          cy    = 1'b0;
        end else begin
          ps[i] = row_s[k*SW+i] ^ row_cs[k*SW+i] ^ cy;
          cy    = (row_s[k*SW+i] & row_cs[k*SW+i]) |
                  (cy & (row_s[k*SW+i] ^ row_cs[k*SW+i]));
        end
      end
      part_co[k] = cy;
      t = (k == 0) ? 1'b0 : up;
      for (int i = 0; i < SW; i++) begin
        low_res[k*SW+i] = ps[i] ^ t;
        t = ps[i] & t;
      end
      inc_co[k] = t;
      up        = cy | t;
      blk_co[k] = up;
    end
  end

  assign total = {row_cs[N] & blk_co[NB-1], row_cs[N] ^ blk_co[NB-1], low_res};

endmodule

// File: rtl/csi_adder3_chk.sv
module csi_adder3_chk #(
  parameter int N = 8
) (
  input logic [N-1:0]     op_a,
  input logic [N-1:0]     op_b,
  input logic [N-1:0]     op_c,
  input logic [N+1:0]     total,
  input logic [N/4-1:0]   part_co,
  input logic [N/4-1:0]   inc_co,
  input logic [N/4-1:0]   blk_co
);
  localparam int NB = N / 4;
  localparam logic [N+1:0] ONES = {2'b00, {N{1'b1}}};
  localparam logic [N+1:0] TOP  = (ONES << 1) + ONES;

  logic [N+1:0] ref_sum;
  logic [3:0]   ref_lo;
  assign ref_sum = {2'b00, op_a} + {2'b00, op_b} + {2'b00, op_c};
  assign ref_lo  = op_a[3:0] + op_b[3:0] + op_c[3:0];

  always_comb begin
    if (!$isunknown({op_a, op_b, op_c})) begin
      AST_SUM_EXACT: assert (total == ref_sum) else $error("sum mismatch"); // R1
      AST_NO_OVERFLOW: assert (total <= TOP) else $error("above maximum"); // R2
      AST_LOW_SLICE: assert (total[3:0] == ref_lo) else $error("low slice"); // R3
      AST_CARRY_EXCLUSIVE: assert ((part_co & inc_co) == '0) else $error("two carries"); // R5
      for (int k = 1; k < NB; k++) begin
        AST_IDLE_INCREMENT: assert (blk_co[k-1] || !inc_co[k]) else $error("idle carry"); // R6
      end
    end
  end
endmodule

bind csi_adder3 csi_adder3_chk #(.N(N)) u_chk (
  .op_a(op_a), .op_b(op_b), .op_c(op_c), .total(total),
  .part_co(part_co), .inc_co(inc_co), .blk_co(blk_co)
);

// File: tb/csi_adder3_tb_top.sv
module csi_adder3_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  a, b, c;
  logic [9:0]  total;
  logic [15:0] wa, wb, wc;
  logic [17:0] wtotal;

  int n_tests = 0;
  int n_fail  = 0;
  longint exp_q[$];
  longint expw_q[$];

  csi_adder3 #(.N(8))  dut_i (.op_a(a), .op_b(b), .op_c(c), .total(total));
  csi_adder3 #(.N(16)) dut_w (.op_a(wa), .op_b(wb), .op_c(wc), .total(wtotal));

  task automatic check(input longint act, input longint expv, input string tag);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic [7:0] z,
                       input logic [15:0] wx, input logic [15:0] wy, input logic [15:0] wz,
                       input string tag);
    @(negedge clk);
    a = x; b = y; c = z;
    wa = wx; wb = wy; wc = wz;
    exp_q.push_back(longint'(x) + longint'(y) + longint'(z));
    expw_q.push_back(longint'(wx) + longint'(wy) + longint'(wz));
    @(posedge clk);
    #1;
    check(longint'(total), exp_q.pop_front(), tag);
    check(longint'(wtotal), expw_q.pop_front(), tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] lo_first;
    a = '0; b = '0; c = '0; wa = '0; wb = '0; wc = '0;
    repeat (3) @(posedge clk);
    #1;
    check(longint'(total), 0, "R7 reset");
    check(longint'(wtotal), 0, "R7 reset");
    rst_n = 1'b1;

    apply(8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, "R7");
    apply(8'hFF, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R2");
    check(longint'(total), 64'h2FD, "R2 max");
    check(longint'(wtotal), 64'h2FFFD, "R9 max");
    apply(8'h0F, 8'h01, 8'h00, 16'h00FF, 16'h0001, 16'h0000, "R4");
    check(longint'(total), 64'h010, "R4 boundary");
    apply(8'hFF, 8'h01, 8'h00, 16'hFFFF, 16'h0001, 16'h0000, "R8");
    check(longint'(wtotal), 64'h10000, "R8 chain");
    apply(8'h30, 8'h40, 8'h05, 16'h0FFF, 16'h0001, 16'h0000, "R6");
    check(longint'(total), 64'h075, "R6 no carry in");
    check(longint'(wtotal), 64'h1000, "R8 three slices");
    apply(8'h35, 8'h46, 8'h07, 16'h1234, 16'h4321, 16'h0F0F, "R3");
    lo_first = total[3:0];
    apply(8'hF5, 8'h06, 8'h97, 16'hABCD, 16'h5555, 16'hFFF0, "R3");
    check(longint'(total[3:0]), longint'(lo_first), "R3 upper bits ignored");
    apply(8'hF8, 8'h08, 8'h08, 16'h8888, 16'h8888, 16'h8888, "R5");
    apply(8'h7F, 8'h80, 8'h01, 16'h7FFF, 16'h8000, 16'h0001, "R4 R8");
    for (int n = 0; n < 3000; n++) begin
      apply(8'($urandom), 8'($urandom), 8'($urandom),
            16'($urandom), 16'($urandom), 16'($urandom), "R1");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule